// File: doc/BRIEF.md
# Program Counter and Memory Address Select Unit

This unit keeps the processor's program counter and its memory address register, and chooses the next value for each. The controller drives select codes and load strobes. On each clock edge where a strobe is high, the matching register loads the source that its select code picks. When the strobe is low, the register keeps its value.

The program counter can step to its own value plus one, take the result of the address adder (used for branches and jumps), or take the shared bus (used for trap handling). The memory address register can take the low byte of the instruction, zero-extended (a trap-vector number), or the address-adder result (used for loads and stores).

The address adder is combinational. It adds a base to a sign-extended offset. The base is either the program counter or a register-file value. The offset is taken from the instruction in one of three widths. The unit also drives the register number that register-relative addressing reads, so the register file can look it up.

Top module: `pc_mar_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes RESET_PC (16'h3000 by default) and `mar` becomes 0. This holds even when the load strobes are high.
- R2: With `pc_ld` high and `pc_src_sel` = 0, `pc` becomes `pc` + 1 at the edge, wrapping from 16'hFFFF to 16'h0000.
- R3: With `pc_ld` high and `pc_src_sel` = 1, `pc` becomes the value `addr_sum` had before the edge.
- R4: With `pc_ld` high and `pc_src_sel` = 2, `pc` becomes the value of `bus` before the edge.
- R5: `pc` keeps its value when `pc_ld` is low, whatever `pc_src_sel` holds. It also keeps its value when `pc_src_sel` = 3, whatever `pc_ld` holds.
- R6: With `mar_ld` high and `mar_src_sel` = 0, `mar` becomes `ir[7:0]` with zeros in bits 15:8.
- R7: With `mar_ld` high and `mar_src_sel` = 1, `mar` becomes the value `addr_sum` had before the edge.
- R8: `mar` keeps its value while `mar_ld` is low.
- R9: `base_sel` = 0 makes the current `pc` the adder base. `base_sel` = 1 makes `reg_val` the adder base.
- R10: The `ofs_sel` code picks the offset, sign-extended to 16 bits: code 0 uses `ir[5:0]`, code 1 uses `ir[8:0]`, code 2 uses `ir[10:0]`, and code 3 uses an offset of zero.
- R11: `addr_sum` is base + offset modulo 2^16 and follows its inputs within the same cycle.
- R12: `base_idx` always equals `ir[8:6]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_src_sel | input | 2 | PC source: 0 increment, 1 adder, 2 bus, 3 hold |
| pc_ld | input | 1 | PC load strobe |
| mar_src_sel | input | 1 | MAR source: 0 zero-extended vector, 1 adder |
| mar_ld | input | 1 | MAR load strobe |
| base_sel | input | 1 | Adder base: 0 PC, 1 register value |
| ofs_sel | input | 2 | Offset width: 0 six bits, 1 nine bits, 2 eleven bits, 3 none |
| ir | input | 16 | Instruction register contents |
| reg_val | input | 16 | Register-file output used as base |
| bus | input | 16 | Shared data bus |
| pc | output | 16 | Program counter |
| mar | output | 16 | Memory address register |
| addr_sum | output | 16 | Address adder result |
| base_idx | output | 3 | Register number for the register-relative base |

## Verification
The bench builds the unit with its defaults: a 16-bit datapath and a reset value of 16'h3000. At this width the bus can load the top address directly. That puts the increment wrap from 16'hFFFF to zero, and a negative eleven-bit offset that carries below address zero, within a few cycles. Each offset width is driven with its sign bit set, so every extension is tested with its top bit set. A reset asserted with both load strobes high confirms that reset takes priority over loading.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    localparam int NUM_OFS = 3;

    typedef enum logic [1:0] {
        PCS_INC   = 2'd0,
        PCS_ADDER = 2'd1,
        PCS_BUS   = 2'd2,
        PCS_HOLD  = 2'd3
    } pc_src_e;

    typedef enum logic {
        MAS_VEC   = 1'b0,
        MAS_ADDER = 1'b1
    } mar_src_e;

    typedef enum logic {
        BASE_PC  = 1'b0,
        BASE_REG = 1'b1
    } base_src_e;

    typedef enum logic [1:0] {
        OFS_6    = 2'd0,
        OFS_9    = 2'd1,
        OFS_11   = 2'd2,
        OFS_NONE = 2'd3
    } ofs_sel_e;

    // Field width taken from the instruction for each offset code
    function automatic int ofs_width(input int idx);
        case (idx)
            0:       return 6;
            1:       return 9;
            default: return 11;
        endcase
    endfunction

endpackage

// File: rtl/pcm_offset_sext.sv
module pcm_offset_sext
    import pcm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] ir,
    input  ofs_sel_e      sel,
    output logic [DW-1:0] offset
);

    logic [DW-1:0] cand [NUM_OFS];

    for (genvar g = 0; g < NUM_OFS; g++) begin : g_ext
        localparam int W = ofs_width(g);
        assign cand[g] = {{(DW-W){ir[W-1]}}, ir[W-1:0]};
    end

    always_comb begin
        case (sel)
            OFS_6:   offset = cand[0];
            OFS_9:   offset = cand[1];
            OFS_11:  offset = cand[2];
            default: offset = '0;
        endcase
    end

endmodule

// File: rtl/pcm_addr_adder.sv
module pcm_addr_adder
    import pcm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] pc,
    input  logic [DW-1:0] reg_val,
    input  base_src_e     base_sel,
    input  logic [DW-1:0] offset,
    output logic [DW-1:0] sum
);

    logic [DW-1:0] base;

    always_comb begin
        base = (base_sel == BASE_REG) ? reg_val : pc;
        sum  = base + offset;
    end

endmodule

// File: rtl/pcm_pc_reg.sv
module pcm_pc_reg
    import pcm_pkg::*;
#(
    parameter int          DW       = 16,
    parameter logic [DW-1:0] RESET_PC = 16'h3000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  pc_src_e       src,
    input  logic [DW-1:0] adder,
    input  logic [DW-1:0] bus,
    output logic [DW-1:0] pc
);

    logic [DW-1:0] pc_next;

    always_comb begin
        case (src)
            PCS_INC:   pc_next = pc + 1'b1;
            PCS_ADDER: pc_next = adder;
            PCS_BUS:   pc_next = bus;
            default:   pc_next = pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     pc <= RESET_PC;
        else if (ld) pc <= pc_next;
    end

    // R2
    pc_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (ld && src == PCS_INC) |=> pc == $past(pc) + 1'b1);
    // R3
    pc_adder_chk: assert property (@(posedge clk) disable iff (rst)
        (ld && src == PCS_ADDER) |=> pc == $past(adder));
    // R4
    pc_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (ld && src == PCS_BUS) |=> pc == $past(bus));
    // R5
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld || src == PCS_HOLD) |=> $stable(pc));

endmodule

// File: rtl/pcm_mar_reg.sv
module pcm_mar_reg
    import pcm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  mar_src_e      src,
    input  logic [7:0]    vec,
    input  logic [DW-1:0] adder,
    output logic [DW-1:0] mar
);

    always_ff @(posedge clk) begin
        if (rst)
            mar <= '0;
        else if (ld)
            mar <= (src == MAS_ADDER) ? adder : {{(DW-8){1'b0}}, vec};
    end

    // R6
    mar_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (ld && src == MAS_VEC) |=> (mar[7:0] == $past(vec) && mar[DW-1:8] == '0));
    // R7
    mar_adder_chk: assert property (@(posedge clk) disable iff (rst)
        (ld && src == MAS_ADDER) |=> mar == $past(adder));
    // R8
    mar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(mar));

endmodule

// File: rtl/pc_mar_unit.sv
module pc_mar_unit
    import pcm_pkg::*;
#(
    parameter int            DW       = 16,
    parameter logic [DW-1:0] RESET_PC = 16'h3000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    pc_src_sel,
    input  logic          pc_ld,
    input  logic          mar_src_sel,
    input  logic          mar_ld,
    input  logic          base_sel,
    input  logic [1:0]    ofs_sel,
    input  logic [DW-1:0] ir,
    input  logic [DW-1:0] reg_val,
    input  logic [DW-1:0] bus,
    output logic [DW-1:0] pc,
    output logic [DW-1:0] mar,
    output logic [DW-1:0] addr_sum,
    output logic [2:0]    base_idx
);

    logic [DW-1:0] offset;

    assign base_idx = ir[8:6];

    pcm_offset_sext #(.DW(DW)) u_sext (
        .ir     (ir),
        .sel    (ofs_sel_e'(ofs_sel)),
        .offset (offset)
    );

    pcm_addr_adder #(.DW(DW)) u_adder (
        .pc       (pc),
        .reg_val  (reg_val),
        .base_sel (base_src_e'(base_sel)),
        .offset   (offset),
        .sum      (addr_sum)
    );

    pcm_pc_reg #(.DW(DW), .RESET_PC(RESET_PC)) u_pc (
        .clk   (clk),
        .rst   (rst),
        .ld    (pc_ld),
        .src   (pc_src_e'(pc_src_sel)),
        .adder (addr_sum),
        .bus   (bus),
        .pc    (pc)
    );

    pcm_mar_reg #(.DW(DW)) u_mar (
        .clk   (clk),
        .rst   (rst),
        .ld    (mar_ld),
        .src   (mar_src_e'(mar_src_sel)),
        .vec   (ir[7:0]),
        .adder (addr_sum),
        .mar   (mar)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (1'b0)
        $fell(rst) |-> (pc == RESET_PC && mar == '0));

endmodule

// File: tb/pc_mar_unit_bench.sv
`timescale 1ns/1ps
module pc_mar_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  pc_src_sel;
    logic        pc_ld;
    logic        mar_src_sel;
    logic        mar_ld;
    logic        base_sel;
    logic [1:0]  ofs_sel;
    logic [15:0] ir, reg_val, bus;
    logic [15:0] pc, mar, addr_sum;
    logic [2:0]  base_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pc_mar_unit u_pc_mar_unit (
        .clk(clk), .rst(rst), .pc_src_sel(pc_src_sel), .pc_ld(pc_ld),
        .mar_src_sel(mar_src_sel), .mar_ld(mar_ld), .base_sel(base_sel),
        .ofs_sel(ofs_sel), .ir(ir), .reg_val(reg_val), .bus(bus),
        .pc(pc), .mar(mar), .addr_sum(addr_sum), .base_idx(base_idx)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [15:0] ir;
        logic [15:0] rv;
        logic [15:0] bus;
        logic        base;
        logic [1:0]  ofs;
        logic [1:0]  pcs;
        logic        pld;
        logic        ms;
        logic        mld;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd2,  16'h0000, 16'h0000, 16'h0000, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0}, // R2 step
        '{4'd3,  16'h01FF, 16'h0000, 16'h0000, 1'b0, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0}, // R3 pc-1 via 9-bit
        '{4'd7,  16'h01BE, 16'h4000, 16'h0000, 1'b1, 2'd0, 2'd3, 1'b0, 1'b1, 1'b1}, // R7 reg-2
        '{4'd6,  16'hF025, 16'h0000, 16'h0000, 1'b0, 2'd3, 2'd3, 1'b0, 1'b0, 1'b1}, // R6 vector
        '{4'd4,  16'h0000, 16'h0000, 16'hFFFF, 1'b0, 2'd3, 2'd2, 1'b1, 1'b0, 1'b0}, // R4 bus
        '{4'd2,  16'h0000, 16'h0000, 16'h0000, 1'b0, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0}, // R2 wrap
        '{4'd11, 16'h0400, 16'h0000, 16'h0000, 1'b0, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0}, // R11 11-bit negative
        '{4'd10, 16'h07FF, 16'h1234, 16'h0000, 1'b1, 2'd3, 2'd3, 1'b0, 1'b1, 1'b1}, // R10 no offset
        '{4'd5,  16'h0000, 16'h0000, 16'hAAAA, 1'b0, 2'd0, 2'd3, 1'b1, 1'b0, 1'b0}, // R5 hold code
        '{4'd5,  16'h0000, 16'h0000, 16'h5555, 1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0}, // R5 no load
        '{4'd8,  16'h00EE, 16'h0000, 16'h0000, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0}, // R8 no load
        '{4'd11, 16'h001F, 16'hFFF0, 16'h0000, 1'b1, 2'd0, 2'd3, 1'b0, 1'b1, 1'b1}  // R11 wrap up, R9
    };

    logic [15:0] m_pc, m_mar;

    function automatic logic [15:0] ref_sum(input logic [15:0] p, input vec_t v);
        logic [15:0] b, o;
        b = v.base ? v.rv : p;                                    // R9
        case (v.ofs)                                              // R10
            2'd0:    o = 16'($signed(v.ir[5:0]));
            2'd1:    o = 16'($signed(v.ir[8:0]));
            2'd2:    o = 16'($signed(v.ir[10:0]));
            default: o = 16'h0000;
        endcase
        return b + o;                                             // R11
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        pc_ld = 1'b0; mar_ld = 1'b0; pc_src_sel = 2'd0; mar_src_sel = 1'b0;
        base_sel = 1'b0; ofs_sel = 2'd0; ir = '0; reg_val = '0; bus = '0;
    endtask

    initial begin
        #50000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 pc", pc, 16'h3000);
        chk("R1 mar", mar, 16'h0000);
        m_pc = 16'h3000; m_mar = 16'h0000;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [15:0] s;
            v = VECS[i];
            ir = v.ir; reg_val = v.rv; bus = v.bus; base_sel = v.base;
            ofs_sel = v.ofs; pc_src_sel = v.pcs; pc_ld = v.pld;
            mar_src_sel = v.ms; mar_ld = v.mld;
            #1;
            s = ref_sum(m_pc, v);
            chk($sformatf("R11/R%0d sum vec %0d", v.req, i), addr_sum, s);
            chk($sformatf("R12 base_idx vec %0d", i), {13'b0, base_idx}, {13'b0, v.ir[8:6]});
            if (v.pld) begin
                case (v.pcs)
                    2'd0: m_pc = m_pc + 16'd1;
                    2'd1: m_pc = s;
                    2'd2: m_pc = v.bus;
                    default: ;
                endcase
            end
            if (v.mld) m_mar = v.ms ? s : {8'h00, v.ir[7:0]};
            @(posedge clk);
            #1;
            pc_ld = 1'b0; mar_ld = 1'b0;
            @(negedge clk);
            chk($sformatf("R%0d pc vec %0d", v.req, i), pc, m_pc);
            chk($sformatf("R%0d mar vec %0d", v.req, i), mar, m_mar);
        end

        // R9: base from pc with 6-bit positive offset, no load
        idle();
        base_sel = 1'b0; ofs_sel = 2'd0; ir = 16'h0005;
        #1;
        chk("R9 pc base", addr_sum, m_pc + 16'd5);

        // R1: reset beats active loads
        @(negedge clk);
        pc_ld = 1'b1; pc_src_sel = 2'd2; bus = 16'h1111;
        mar_ld = 1'b1; mar_src_sel = 1'b0; ir = 16'h00FF;
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0; pc_ld = 1'b0; mar_ld = 1'b0;
        @(negedge clk);
        chk("R1 pc under load", pc, 16'h3000);
        chk("R1 mar under load", mar, 16'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule